// File: doc/BRIEF.md
# Vertex Attribute Input Permuter

This block sits between an attribute stream and the input register file of a shader unit. Attributes of one vertex come in as 128-bit values, one on each cycle in which `attr_valid` is high, in attribute order. Each one is written to the input register that the programmable permutation picks for that attribute slot. When the configured number of attributes has arrived, the block pulses `vtx_done` and starts over with attribute 0 of the next vertex.

A small configuration port loads three 32-bit words. Two permutation words hold sixteen 4-bit destination fields. A buffer word holds the attribute count minus one and a geometry-stage selection byte. Writes go into shadow copies. The copy used for routing is refreshed only when a vertex begins, so a reconfiguration never changes the routing of a vertex that is already in progress.

Top module: `vtx_attr_permuter`

## Requirements
- R1: After reset `rf_we`, `vtx_done` and `geom_used` are low. Both permutation words hold the identity mapping, so attribute n goes to register n. The attribute count is 1, because the buffer word resets to 0xA000_0000.
- R2: `cfg_sel` selects the target word: 0 is the low permutation word, 1 the high permutation word, 2 the buffer word. Attribute n < 8 takes its destination from bits [4n+3:4n] of the low word. Attribute n >= 8 uses bits [4(n-8)+3:4(n-8)] of the high word. A field value k sends the attribute to register k.
- R3: An attribute accepted at a clock edge appears on the write port at the next edge: `rf_we` high, `rf_waddr` set to its destination, and `rf_wdata` equal to the accepted `attr_data`.
- R4: Bits [3:0] of the buffer word hold the attribute count minus one. `vtx_done` is high for exactly the one cycle in which the last attribute of a vertex is written.
- R5: After the last attribute the counter returns to zero, so the next accepted attribute is attribute 0 of a new vertex. A count of one makes every attribute a complete vertex.
- R6: Cycles with `attr_valid` low produce no write and no done pulse, and they do not advance the attribute position.
- R7: When several attributes map to the same register, every one is written in stream order, so the register ends up holding the later attribute.
- R8: A configuration write made while a vertex is in progress changes neither the routing nor the count of that vertex. It applies from the first attribute of the next vertex.
- R9: `geom_used` is high only when bits [31:24] of the buffer word in effect equal 0x08. A value of 0xA0, or any other value, keeps it low.
- R10: A configuration write with `cfg_sel` = 3 changes nothing: routing, count and `geom_used` stay as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| attr_valid | input | 1 | Attribute present this cycle |
| attr_data | input | 128 | Attribute value |
| rf_we | output | 1 | Input register file write enable |
| rf_waddr | output | 4 | Destination input register |
| rf_wdata | output | 128 | Data written to the register |
| vtx_done | output | 1 | One-cycle pulse with the last attribute of a vertex |
| geom_used | output | 1 | Geometry stage selected by the buffer word in effect |

## Verification
The bench writes configuration in the middle of a vertex and then checks two things. The vertex in progress must keep its old routing and old done position. The following vertex must switch to the new ones. A design that applied writes at once would scatter the remaining attributes and end the vertex early or late. Mappings that all point at one register, a count of one, and a full count of sixteen test the write ordering and the counter wrap. A wrong counter would pulse `vtx_done` at the wrong attribute or mislabel the first attribute of the next vertex. Gaps in `attr_valid`, writes to the unused select code, and geometry codes other than 0x08 are all checked to have no effect on the outputs.

// File: rtl/vap_pkg.sv
package vap_pkg;

    localparam int unsigned CFG_W     = 32;
    localparam int unsigned FIELD_W   = 4;
    localparam int unsigned WORD_FLDS = CFG_W / FIELD_W;

    typedef enum logic [1:0] {
        SEL_PERM_LO = 2'd0,
        SEL_PERM_HI = 2'd1,
        SEL_BUFCFG  = 2'd2,
        SEL_SPARE   = 2'd3
    } cfg_sel_e;

    localparam logic [7:0] GEOM_ON_CODE  = 8'h08;
    localparam logic [7:0] GEOM_OFF_CODE = 8'hA0;

    typedef struct packed {
        logic [7:0]         geom_code;
        logic [FIELD_W-1:0] last_idx;
    } buf_cfg_t;

    typedef struct packed {
        logic [CFG_W-1:0] perm_hi;
        logic [CFG_W-1:0] perm_lo;
        buf_cfg_t         bcfg;
    } cfg_set_t;

    function automatic logic [CFG_W-1:0] identity_word(input int unsigned base);
        logic [CFG_W-1:0] w;
        w = '0;
        for (int unsigned i = 0; i < WORD_FLDS; i++) begin
            w[i*FIELD_W +: FIELD_W] = FIELD_W'(base + i);
        end
        return w;
    endfunction

    function automatic cfg_set_t reset_cfg();
        cfg_set_t c;
        c.perm_lo        = identity_word(0);
        c.perm_hi        = identity_word(WORD_FLDS);
        c.bcfg.geom_code = GEOM_OFF_CODE;
        c.bcfg.last_idx  = '0;
        return c;
    endfunction

endpackage

// File: rtl/vap_cfg_regs.sv
module vap_cfg_regs
    import vap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             at_start,
    input  logic             accept,
    output cfg_set_t         eff_cfg
);
    cfg_set_t shadow_q;
    cfg_set_t active_q;
    cfg_sel_e sel;

    assign sel = cfg_sel_e'(cfg_sel);

    wire unused_cfg_bits = ^cfg_wdata[23:FIELD_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= reset_cfg();
        end else if (cfg_we) begin
            case (sel)
                SEL_PERM_LO: shadow_q.perm_lo <= cfg_wdata;
                SEL_PERM_HI: shadow_q.perm_hi <= cfg_wdata;
                SEL_BUFCFG: begin
                    shadow_q.bcfg.geom_code <= cfg_wdata[31:24];
                    shadow_q.bcfg.last_idx  <= cfg_wdata[FIELD_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // the set in use is captured when the first attribute of a vertex is taken
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= reset_cfg();
        end else if (at_start && accept) begin
            active_q <= shadow_q;
        end
    end

    assign eff_cfg = at_start ? shadow_q : active_q;

endmodule

// File: rtl/vap_attr_seq.sv
module vap_attr_seq #(
    parameter int unsigned MAX_ATTR = 16,
    localparam int unsigned CNT_W   = $clog2(MAX_ATTR)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [CNT_W-1:0] last_idx,
    output logic [CNT_W-1:0] pos,
    output logic             at_start,
    output logic             done_q
);
    logic [CNT_W-1:0] pos_q;
    logic             is_last;

    assign is_last  = (pos_q == last_idx);
    assign pos      = pos_q;
    assign at_start = (pos_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= accept && is_last;
            if (accept) begin
                pos_q <= is_last ? '0 : pos_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vap_route.sv
module vap_route
    import vap_pkg::*;
#(
    parameter int unsigned DATA_W   = 128,
    parameter int unsigned MAX_ATTR = 16,
    localparam int unsigned CNT_W   = $clog2(MAX_ATTR)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic [CNT_W-1:0]   pos,
    input  logic [CFG_W-1:0]   perm_lo,
    input  logic [CFG_W-1:0]   perm_hi,
    input  logic [DATA_W-1:0]  data_in,
    output logic               we_q,
    output logic [FIELD_W-1:0] addr_q,
    output logic [DATA_W-1:0]  data_q
);
    logic [FIELD_W-1:0] dest_tab [MAX_ATTR];

    for (genvar g = 0; g < MAX_ATTR; g++) begin : g_fld
        if (g < WORD_FLDS) begin : g_lo
            assign dest_tab[g] = perm_lo[g*FIELD_W +: FIELD_W];
        end else begin : g_hi
            assign dest_tab[g] = perm_hi[(g-WORD_FLDS)*FIELD_W +: FIELD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            we_q <= accept;
            if (accept) begin
                addr_q <= dest_tab[pos];
                data_q <= data_in;
            end
        end
    end

endmodule

// File: rtl/vtx_attr_permuter.sv
module vtx_attr_permuter
    import vap_pkg::*;
#(
    parameter int unsigned DATA_W   = 128,
    parameter int unsigned MAX_ATTR = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               attr_valid,
    input  logic [DATA_W-1:0]  attr_data,
    output logic               rf_we,
    output logic [FIELD_W-1:0] rf_waddr,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic               vtx_done,
    output logic               geom_used
);
    localparam int unsigned CNT_W = $clog2(MAX_ATTR);

    cfg_set_t         eff_cfg;
    logic [CNT_W-1:0] pos;
    logic             at_start;

    vap_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .at_start  (at_start),
        .accept    (attr_valid),
        .eff_cfg   (eff_cfg)
    );

    vap_attr_seq #(.MAX_ATTR(MAX_ATTR)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept   (attr_valid),
        .last_idx (eff_cfg.bcfg.last_idx[CNT_W-1:0]),
        .pos      (pos),
        .at_start (at_start),
        .done_q   (vtx_done)
    );

    vap_route #(.DATA_W(DATA_W), .MAX_ATTR(MAX_ATTR)) u_route (
        .clk     (clk),
        .rst     (rst),
        .accept  (attr_valid),
        .pos     (pos),
        .perm_lo (eff_cfg.perm_lo),
        .perm_hi (eff_cfg.perm_hi),
        .data_in (attr_data),
        .we_q    (rf_we),
        .addr_q  (rf_waddr),
        .data_q  (rf_wdata)
    );

    assign geom_used = (eff_cfg.bcfg.geom_code == GEOM_ON_CODE);

endmodule

// File: rtl/vap_checker.sv
module vap_checker #(
    parameter int unsigned DATA_W   = 128,
    parameter int unsigned MAX_ATTR = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              attr_valid,
    input logic [DATA_W-1:0] attr_data,
    input logic              rf_we,
    input logic [3:0]        rf_waddr,
    input logic [DATA_W-1:0] rf_wdata,
    input logic              vtx_done,
    input logic              geom_used
);
    logic [5:0] since_done;
    wire unused_chk = ^{rf_waddr, geom_used};

    always_ff @(posedge clk) begin
        if (rst) begin
            since_done <= '0;
        end else if (vtx_done) begin
            since_done <= {5'd0, attr_valid};
        end else if (attr_valid) begin
            since_done <= since_done + 6'd1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!rf_we && !vtx_done));

    p_write_follows_r3: assert property (@(posedge clk) disable iff (rst)
        attr_valid |=> (rf_we && rf_wdata == $past(attr_data)));

    p_done_with_write_r4: assert property (@(posedge clk) disable iff (rst)
        vtx_done |-> rf_we);

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !attr_valid |=> (!rf_we && !vtx_done));

    p_vertex_bound_r5: assert property (@(posedge clk) disable iff (rst)
        attr_valid |-> (since_done < 6'(MAX_ATTR) + 6'd1));

endmodule

bind vtx_attr_permuter vap_checker #(.DATA_W(DATA_W), .MAX_ATTR(MAX_ATTR)) u_vap_chk (
    .clk        (clk),
    .rst        (rst),
    .attr_valid (attr_valid),
    .attr_data  (attr_data),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata),
    .vtx_done   (vtx_done),
    .geom_used  (geom_used)
);

// File: tb/vtx_attr_permuter_bench.sv
`timescale 1ns/1ps
module vtx_attr_permuter_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_sel = 2'd0;
    logic [31:0]  cfg_wdata = '0;
    logic         attr_valid = 1'b0;
    logic [127:0] attr_data = '0;
    logic         rf_we;
    logic [3:0]   rf_waddr;
    logic [127:0] rf_wdata;
    logic         vtx_done;
    logic         geom_used;

    int n_vec = 0;
    int n_bad = 0;

    // bench model of configuration and attribute position
    logic [31:0]  s_lo, s_hi, s_buf, a_lo, a_hi, a_buf;
    int           m_pos;
    logic [127:0] seen_rf [16];

    always #2.5 clk = ~clk;

    vtx_attr_permuter u_vtx_attr_permuter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .attr_valid(attr_valid), .attr_data(attr_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .vtx_done(vtx_done), .geom_used(geom_used)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ident(input int base);
        logic [31:0] w;
        for (int i = 0; i < 8; i++) w[i*4 +: 4] = 4'(base + i);
        return w;
    endfunction

    function automatic logic [3:0] dest_of(input logic [31:0] lo, input logic [31:0] hi,
                                           input int n);
        return (n < 8) ? lo[n*4 +: 4] : hi[(n-8)*4 +: 4];
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) s_lo = d;
        else if (sel == 2'd1) s_hi = d;
        else if (sel == 2'd2) s_buf = d;
    endtask

    task automatic push(input logic v, input logic [127:0] d, input string req);
        logic [31:0] elo, ehi, ebuf;
        logic [3:0]  eaddr;
        logic        edone;
        elo  = (m_pos == 0) ? s_lo  : a_lo;
        ehi  = (m_pos == 0) ? s_hi  : a_hi;
        ebuf = (m_pos == 0) ? s_buf : a_buf;
        eaddr = dest_of(elo, ehi, m_pos);
        edone = v && (m_pos == int'(ebuf[3:0]));
        attr_valid = v; attr_data = d;
        @(posedge clk); @(negedge clk);
        attr_valid = 1'b0;
        check(rf_we == v, {req, " rf_we"}, 128'(rf_we), 128'(v));
        check(vtx_done == edone, {req, " vtx_done"}, 128'(vtx_done), 128'(edone));
        if (v) begin
            check(rf_waddr == eaddr, {req, " rf_waddr"}, 128'(rf_waddr), 128'(eaddr));
            check(rf_wdata == d, {req, " rf_wdata"}, rf_wdata, d);
            if (rf_we) seen_rf[rf_waddr] = rf_wdata;
            if (m_pos == 0) begin a_lo = s_lo; a_hi = s_hi; a_buf = s_buf; end
            m_pos = edone ? 0 : m_pos + 1;
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [127:0] d1, d2, d3;
        void'($urandom(32'h5eed_0042));
        s_lo = ident(0); s_hi = ident(8); s_buf = 32'hA000_0000;
        a_lo = s_lo; a_hi = s_hi; a_buf = s_buf; m_pos = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(!rf_we && !vtx_done, "R1 outputs after reset", 128'({rf_we, vtx_done}), 128'(0));
        check(!geom_used, "R1 geom_used after reset", 128'(geom_used), 128'(0));
        // R1/R5: count of one, every attribute goes to v0 and completes a vertex
        for (int i = 0; i < 3; i++) push(1'b1, rnd128(), "R1 default count R5");

        // R1/R2: identity with 16 attributes, R4 done on the 16th
        cfg_write(2'd2, 32'hA000_000F);
        for (int i = 0; i < 16; i++) push(1'b1, rnd128(), "R2 identity R4");

        // R2: explicit fields in both words
        cfg_write(2'd0, 32'h0123_4567);
        cfg_write(2'd1, 32'h89AB_CDEF);
        for (int i = 0; i < 16; i++) push(1'b1, rnd128(), "R2 reversed map");

        // R6: gaps inside a vertex
        cfg_write(2'd2, 32'hA000_0003);
        push(1'b1, rnd128(), "R6 gap");
        push(1'b0, '0, "R6 idle");
        push(1'b0, '0, "R6 idle");
        push(1'b1, rnd128(), "R6 gap");
        push(1'b0, '0, "R6 idle");
        push(1'b1, rnd128(), "R6 gap");
        push(1'b1, rnd128(), "R6 gap R4");

        // R7: three attributes all to v3, last one wins
        cfg_write(2'd0, 32'h3333_3333);
        cfg_write(2'd2, 32'hA000_0002);
        d1 = rnd128(); d2 = rnd128(); d3 = rnd128();
        push(1'b1, d1, "R7 dup");
        push(1'b1, d2, "R7 dup");
        push(1'b1, d3, "R7 dup");
        check(seen_rf[3] == d3, "R7 last write wins", seen_rf[3], d3);

        // R8: mid-vertex write deferred
        cfg_write(2'd0, 32'h7654_3210);
        cfg_write(2'd2, 32'hA000_0003);
        push(1'b1, rnd128(), "R8 before");
        push(1'b1, rnd128(), "R8 before");
        cfg_write(2'd0, 32'hFEDC_BA98);
        cfg_write(2'd2, 32'h0800_0001);
        push(1'b1, rnd128(), "R8 old map");
        push(1'b1, rnd128(), "R8 old count");
        check(geom_used, "R9 geom on after new vertex start", 128'(geom_used), 128'(1));
        push(1'b1, rnd128(), "R8 new map");
        push(1'b1, rnd128(), "R8 new count");

        // R9: other codes keep geom_used low
        cfg_write(2'd2, 32'hA000_0000);
        check(!geom_used, "R9 code A0", 128'(geom_used), 128'(0));
        cfg_write(2'd2, 32'h0900_0000);
        check(!geom_used, "R9 code 09", 128'(geom_used), 128'(0));
        cfg_write(2'd2, 32'h0800_0000);
        check(geom_used, "R9 code 08", 128'(geom_used), 128'(1));

        // R10: spare select has no effect
        cfg_write(2'd2, 32'hA000_0001);
        cfg_write(2'd3, 32'h0800_000F);
        check(!geom_used, "R10 spare select geom", 128'(geom_used), 128'(0));
        push(1'b1, rnd128(), "R10 spare select");
        push(1'b1, rnd128(), "R10 spare select count");

        // random vertices with random configuration and gaps
        for (int v = 0; v < 60; v++) begin
            if ($urandom_range(0, 1) == 1) cfg_write(2'd0, $urandom());
            if ($urandom_range(0, 1) == 1) cfg_write(2'd1, $urandom());
            if ($urandom_range(0, 2) == 0)
                cfg_write(2'd2, {($urandom_range(0, 1) == 1) ? 8'h08 : 8'hA0, 20'd0,
                                 4'($urandom_range(0, 15))});
            for (int k = 0; k < 20; k++) begin
                if ($urandom_range(0, 3) == 0) push(1'b0, '0, "R6 random idle");
                else push(1'b1, rnd128(), "R3 random R4 R8");
                if ($urandom_range(0, 9) == 0) cfg_write(2'd0, $urandom());
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule